// File: doc/BRIEF.md
# Lane-Striped Vector Element Sequencer

This block is one vector functional unit together with the vector register file it works on. It accepts one vector instruction at a time through a valid/ready issue port. It then walks through the instruction's elements in groups, one group per clock. A group is one element from each of the parallel lanes. Element `i` of every register sits in lane `i mod 8`, at group `i div 8`. Each lane reads its two operands from its own slice of the register file, runs them through a small 32-bit ALU (add, subtract, bitwise logic, shifts) and writes the result back into the destination register at the same position.

A full-length instruction keeps the unit occupied for four cycles. The issue port raises ready again during the final group, so that a following instruction starts in the very next cycle and already sees the results just written. A vector length of zero is accepted and retires at once. Elements at or above the vector length are left untouched. A combinational read port lets the surrounding logic inspect any element of any register.

Top module: `vlane_seq`

## Requirements
- R1: After reset every element of every register reads 0, `busy` is low and `issue_ready` is high.
- R2: The register file holds 16 registers of 32 elements, each element 32 bits wide. `rd_data` always shows element `rd_elem` of register `rd_vreg` without any clock delay.
- R3: `issue_op[2:0]` selects the per-element function of operand A (register `issue_vs1`) and operand B. The codes are 0 add, 1 subtract (A-B), 2 and, 3 or, 4 xor, 5 shift left logical, 6 shift right logical and 7 shift right arithmetic. Shifts use only B[4:0] as the amount, and all results wrap modulo 2^32. The result goes to element `i` of register `issue_vd`.
- R4: When `issue_op[3]` is 0, operand B of element `i` is element `i` of register `issue_vs2`. When it is 1, operand B of element `i` is `issue_scalar + i` modulo 2^32.
- R5: An accepted instruction with vector length `L > 0` keeps `busy` high for exactly ceil(L/8) cycles, starting in the cycle after acceptance. In each of those cycles it processes one group, in ascending order.
- R6: `issue_ready` is high whenever the unit is idle or processing its final group, and low otherwise. An instruction accepted during a final group starts in the next cycle and reads the results of the previous instruction.
- R7: An instruction with length 0 is accepted, changes no element and leaves `busy` low. Lengths above 32 are treated as 32.
- R8: Elements of the destination register with index at or above the vector length keep their previous values.
- R9: When a source register is also the destination, every element is computed from that element's value before the instruction.
- R10: While `issue_ready` is low, `issue_valid` and the issue fields have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Instruction will be taken on this edge if offered |
| issue_op | input | 4 | Bit 3: scalar-ramp operand B; bits 2:0: function |
| issue_vs1 | input | 4 | Operand A register |
| issue_vs2 | input | 4 | Operand B register (vector mode) |
| issue_vd | input | 4 | Destination register |
| issue_vl | input | 6 | Vector length, 0 to 32 |
| issue_scalar | input | 32 | Scalar base for ramp operand |
| busy | output | 1 | An instruction still has groups in flight |
| rd_vreg | input | 4 | Inspection port register number |
| rd_elem | input | 5 | Inspection port element index |
| rd_data | output | 32 | Selected element value |

## Verification
Tail lengths are the sharpest corner. A length such as 13 or 25 ends partway through a group, so a design that masks by group instead of by element would overwrite the tail, and an off-by-one in the final-group test would stretch or shorten `busy` by a cycle. A length of zero has to retire without a single write; a design that starts the group walk anyway would clobber all of group 0. Back-to-back issue probes the early ready: if ready rose too late, a cycle would be lost, and if it rose too early, the second instruction would read stale operands. Held-valid stimulus while busy checks that nothing is taken before ready. The in-place cases with a register as both source and destination, together with the scalar-ramp operand, catch read-after-write ordering faults and errors in the element index.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    // Per-element function, carried in the low three opcode bits
    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_XOR = 3'd4,
        FN_SLL = 3'd5,
        FN_SRL = 3'd6,
        FN_SRA = 3'd7
    } vfunc_e;

    localparam int OP_W        = 4;
    localparam int OP_SCALAR_B = 3;

endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int NUM_ELEMS = 32,
    parameter int LANES     = 8,
    parameter int ELEM_W    = 32,
    parameter int REG_AW    = 4,
    parameter int VL_W      = 6,
    parameter int GRP_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [OP_W-1:0]   issue_op,
    input  logic [REG_AW-1:0] issue_vs1,
    input  logic [REG_AW-1:0] issue_vs2,
    input  logic [REG_AW-1:0] issue_vd,
    input  logic [VL_W-1:0]   issue_vl,
    input  logic [ELEM_W-1:0] issue_scalar,
    output logic              active,
    output logic [GRP_W-1:0]  grp,
    output vfunc_e            func,
    output logic              use_scalar,
    output logic [REG_AW-1:0] vs1,
    output logic [REG_AW-1:0] vs2,
    output logic [REG_AW-1:0] vd,
    output logic [VL_W-1:0]   vl,
    output logic [ELEM_W-1:0] scalar
);

    typedef struct packed {
        logic              active;
        logic [GRP_W-1:0]  grp;
        vfunc_e            func;
        logic              use_scalar;
        logic [REG_AW-1:0] vs1;
        logic [REG_AW-1:0] vs2;
        logic [REG_AW-1:0] vd;
        logic [VL_W-1:0]   vl;
        logic [ELEM_W-1:0] scalar;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic            last_grp;
    logic            fire;
    logic [VL_W-1:0] vl_eff;

    always_comb begin
        // final group: the next group would start at or past the length
        last_grp    = st_q.active &&
                      ((int'(st_q.grp) + 1) * LANES >= int'(st_q.vl));
        issue_ready = !st_q.active || last_grp;
        fire        = issue_valid && issue_ready;
        vl_eff      = (issue_vl > VL_W'(NUM_ELEMS)) ? VL_W'(NUM_ELEMS) : issue_vl;

        st_d = st_q;
        if (st_q.active) begin
            if (last_grp) begin
                st_d.active = 1'b0;
            end else begin
                st_d.grp = st_q.grp + 1'b1;
            end
        end
        if (fire) begin
            st_d.active     = (vl_eff != '0);
            st_d.grp        = '0;
            st_d.func       = vfunc_e'(issue_op[2:0]);
            st_d.use_scalar = issue_op[OP_SCALAR_B];
            st_d.vs1        = issue_vs1;
            st_d.vs2        = issue_vs2;
            st_d.vd         = issue_vd;
            st_d.vl         = vl_eff;
            st_d.scalar     = issue_scalar;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, grp: '0, func: FN_ADD, use_scalar: 1'b0,
                      vs1: '0, vs2: '0, vd: '0, vl: '0, scalar: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active     = st_q.active;
    assign grp        = st_q.grp;
    assign func       = st_q.func;
    assign use_scalar = st_q.use_scalar;
    assign vs1        = st_q.vs1;
    assign vs2        = st_q.vs2;
    assign vd         = st_q.vd;
    assign vl         = st_q.vl;
    assign scalar     = st_q.scalar;

endmodule

// File: rtl/vseq_lane.sv
module vseq_lane
    import vseq_pkg::*;
#(
    parameter int LANE      = 0,
    parameter int LANES     = 8,
    parameter int NUM_REGS  = 16,
    parameter int GROUPS    = 4,
    parameter int ELEM_W    = 32,
    parameter int REG_AW    = 4,
    parameter int VL_W      = 6,
    parameter int GRP_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [GRP_W-1:0]  grp,
    input  vfunc_e            func,
    input  logic              use_scalar,
    input  logic [REG_AW-1:0] vs1,
    input  logic [REG_AW-1:0] vs2,
    input  logic [REG_AW-1:0] vd,
    input  logic [VL_W-1:0]   vl,
    input  logic [ELEM_W-1:0] scalar,
    input  logic [REG_AW-1:0] dbg_reg,
    input  logic [GRP_W-1:0]  dbg_grp,
    output logic [ELEM_W-1:0] dbg_data,
    output logic              wr_en
);

    localparam int SH_W = $clog2(ELEM_W);

    // this lane's slice: one element per register per group
    logic [ELEM_W-1:0] bank_q [NUM_REGS][GROUPS];
    logic [ELEM_W-1:0] bank_d [NUM_REGS][GROUPS];

    logic [VL_W-1:0]   elem_idx;
    logic [ELEM_W-1:0] op_a, op_b, res;

    always_comb begin
        elem_idx = VL_W'(int'(grp) * LANES + LANE);
        wr_en    = active && (elem_idx < vl);
        op_a     = bank_q[vs1][grp];
        op_b     = use_scalar ? (scalar + ELEM_W'(elem_idx)) : bank_q[vs2][grp];

        case (func)
            FN_ADD:  res = op_a + op_b;
            FN_SUB:  res = op_a - op_b;
            FN_AND:  res = op_a & op_b;
            FN_OR:   res = op_a | op_b;
            FN_XOR:  res = op_a ^ op_b;
            FN_SLL:  res = op_a << op_b[SH_W-1:0];
            FN_SRL:  res = op_a >> op_b[SH_W-1:0];
            FN_SRA:  res = ELEM_W'($signed(op_a) >>> op_b[SH_W-1:0]);
            default: res = '0;
        endcase

        // group read above happens from the current state, the write lands at the edge
        bank_d = bank_q;
        if (wr_en) begin
            bank_d[vd][grp] = res;
        end

        dbg_data = bank_q[dbg_reg][dbg_grp];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                for (int g = 0; g < GROUPS; g++) begin
                    bank_q[r][g] <= '0;
                end
            end
        end else begin
            bank_q <= bank_d;
        end
    end

endmodule

// File: rtl/vlane_seq.sv
module vlane_seq
    import vseq_pkg::*;
#(
    parameter int NUM_REGS  = 16,
    parameter int NUM_ELEMS = 32,
    parameter int ELEM_W    = 32,
    parameter int LANES     = 8,
    localparam int GROUPS   = (NUM_ELEMS + LANES - 1) / LANES,
    localparam int REG_AW   = $clog2(NUM_REGS),
    localparam int EIDX_W   = $clog2(NUM_ELEMS),
    localparam int VL_W     = $clog2(NUM_ELEMS + 1),
    localparam int LANE_W   = $clog2(LANES),
    localparam int GRP_W    = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [OP_W-1:0]   issue_op,
    input  logic [REG_AW-1:0] issue_vs1,
    input  logic [REG_AW-1:0] issue_vs2,
    input  logic [REG_AW-1:0] issue_vd,
    input  logic [VL_W-1:0]   issue_vl,
    input  logic [ELEM_W-1:0] issue_scalar,
    output logic              busy,
    input  logic [REG_AW-1:0] rd_vreg,
    input  logic [EIDX_W-1:0] rd_elem,
    output logic [ELEM_W-1:0] rd_data
);

    logic              ctrl_active;
    logic [GRP_W-1:0]  ctrl_grp;
    vfunc_e            ctrl_func;
    logic              ctrl_scalar_b;
    logic [REG_AW-1:0] ctrl_vs1, ctrl_vs2, ctrl_vd;
    logic [VL_W-1:0]   ctrl_vl;
    logic [ELEM_W-1:0] ctrl_scalar;

    logic [LANES-1:0]  lane_we;
    logic [ELEM_W-1:0] lane_dbg [LANES];
    logic [LANE_W-1:0] dbg_lane;
    logic [GRP_W-1:0]  dbg_grp;

    vseq_ctrl #(
        .NUM_ELEMS (NUM_ELEMS),
        .LANES     (LANES),
        .ELEM_W    (ELEM_W),
        .REG_AW    (REG_AW),
        .VL_W      (VL_W),
        .GRP_W     (GRP_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_valid  (issue_valid),
        .issue_ready  (issue_ready),
        .issue_op     (issue_op),
        .issue_vs1    (issue_vs1),
        .issue_vs2    (issue_vs2),
        .issue_vd     (issue_vd),
        .issue_vl     (issue_vl),
        .issue_scalar (issue_scalar),
        .active       (ctrl_active),
        .grp          (ctrl_grp),
        .func         (ctrl_func),
        .use_scalar   (ctrl_scalar_b),
        .vs1          (ctrl_vs1),
        .vs2          (ctrl_vs2),
        .vd           (ctrl_vd),
        .vl           (ctrl_vl),
        .scalar       (ctrl_scalar)
    );

    // element index splits into lane (low bits) and group (high bits)
    assign dbg_lane = rd_elem[LANE_W-1:0];
    assign dbg_grp  = GRP_W'(rd_elem >> LANE_W);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vseq_lane #(
            .LANE     (l),
            .LANES    (LANES),
            .NUM_REGS (NUM_REGS),
            .GROUPS   (GROUPS),
            .ELEM_W   (ELEM_W),
            .REG_AW   (REG_AW),
            .VL_W     (VL_W),
            .GRP_W    (GRP_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .active     (ctrl_active),
            .grp        (ctrl_grp),
            .func       (ctrl_func),
            .use_scalar (ctrl_scalar_b),
            .vs1        (ctrl_vs1),
            .vs2        (ctrl_vs2),
            .vd         (ctrl_vd),
            .vl         (ctrl_vl),
            .scalar     (ctrl_scalar),
            .dbg_reg    (rd_vreg),
            .dbg_grp    (dbg_grp),
            .dbg_data   (lane_dbg[l]),
            .wr_en      (lane_we[l])
        );
    end

    assign rd_data = lane_dbg[dbg_lane];
    assign busy    = ctrl_active;

endmodule

// File: rtl/vlane_seq_chk.sv
module vlane_seq_chk #(
    parameter int LANES  = 8,
    parameter int GROUPS = 4,
    parameter int VL_W   = 6,
    parameter int GRP_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_valid,
    input logic             issue_ready,
    input logic [VL_W-1:0]  issue_vl,
    input logic             busy,
    input logic [GRP_W-1:0] ctrl_grp,
    input logic [VL_W-1:0]  ctrl_vl,
    input logic [LANES-1:0] lane_we
);

    logic       fire;
    logic [7:0] run_cnt;
    int         exp_we;

    assign fire = issue_valid && issue_ready;

    // busy cycles since the last acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (fire) begin
            run_cnt <= '0;
        end else if (busy && run_cnt != 8'hff) begin
            run_cnt <= run_cnt + 8'd1;
        end
    end

    always_comb begin
        exp_we = int'(ctrl_vl) - int'(ctrl_grp) * LANES;
        if (exp_we > LANES) exp_we = LANES;
        if (exp_we < 0)     exp_we = 0;
    end

    a_r1_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> issue_ready);

    a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && issue_vl != '0) |=> busy);

    a_r7_zero_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && issue_vl == '0) |=> !busy);

    a_r5_group_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !issue_ready) |=> (busy && ctrl_grp == GRP_W'($past(ctrl_grp) + 1'b1)));

    a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < 8'(GROUPS)));

    a_r8_tail_masked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(lane_we) == exp_we));

    a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lane_we == '0));

endmodule

bind vlane_seq vlane_seq_chk #(
    .LANES  (LANES),
    .GROUPS (GROUPS),
    .VL_W   (VL_W),
    .GRP_W  (GRP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .issue_vl    (issue_vl),
    .busy        (busy),
    .ctrl_grp    (ctrl_grp),
    .ctrl_vl     (ctrl_vl),
    .lane_we     (lane_we)
);

// File: tb/vlane_seq_tb.sv
module vlane_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [3:0]  issue_op = '0;
    logic [3:0]  issue_vs1 = '0, issue_vs2 = '0, issue_vd = '0;
    logic [5:0]  issue_vl = '0;
    logic [31:0] issue_scalar = '0;
    logic        busy;
    logic [3:0]  rd_vreg = '0;
    logic [4:0]  rd_elem = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] mdl [16][32];

    always #4 clk = ~clk;

    vlane_seq u_dut (
        .clk (clk), .rst_n (rst_n),
        .issue_valid (issue_valid), .issue_ready (issue_ready),
        .issue_op (issue_op), .issue_vs1 (issue_vs1), .issue_vs2 (issue_vs2),
        .issue_vd (issue_vd), .issue_vl (issue_vl), .issue_scalar (issue_scalar),
        .busy (busy), .rd_vreg (rd_vreg), .rd_elem (rd_elem), .rd_data (rd_data)
    );

    function automatic logic [31:0] m_alu(logic [2:0] f, logic [31:0] a, logic [31:0] b);
        case (f)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return a << b[4:0];
            3'd6: return a >> b[4:0];
            default: return 32'($signed(a) >>> b[4:0]);
        endcase
    endfunction

    task automatic m_exec(logic [3:0] op, logic [3:0] s1, logic [3:0] s2, logic [3:0] d,
                          int vl, logic [31:0] sc);
        int len = (vl > 32) ? 32 : vl;
        for (int i = 0; i < len; i++) begin
            logic [31:0] b = op[3] ? sc + 32'(i) : mdl[s2][i];
            mdl[d][i] = m_alu(op[2:0], mdl[s1][i], b);
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // call only while idle; realigns to a falling edge afterwards
    task automatic check_reg(int r, string tag);
        for (int e = 0; e < 32; e++) begin
            rd_vreg = 4'(r);
            rd_elem = 5'(e);
            #1;
            check(tag, rd_data, mdl[r][e], $sformatf("v%0d[%0d]", r, e));
        end
        @(negedge clk);
    endtask

    // drive at a falling edge, return at the falling edge after acceptance
    task automatic issue(logic [3:0] op, logic [3:0] s1, logic [3:0] s2, logic [3:0] d,
                         int vl, logic [31:0] sc);
        issue_valid = 1'b1; issue_op = op; issue_vs1 = s1; issue_vs2 = s2;
        issue_vd = d; issue_vl = 6'(vl); issue_scalar = sc;
        while (!issue_ready) @(negedge clk);
        @(negedge clk);
        issue_valid = 1'b0;
        m_exec(op, s1, s2, d, vl, sc);
    endtask

    task automatic busy_len(int vl, string tag);
        int len = (vl > 32) ? 32 : vl;
        int cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        check(tag, 32'(cnt), 32'((len + 7) / 8), "busy cycles");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1badcafe));
        for (int r = 0; r < 16; r++)
            for (int e = 0; e < 32; e++) mdl[r][e] = '0;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", 32'(busy), 32'd0, "busy after reset");
        check("R1", 32'(issue_ready), 32'd1, "ready after reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reg(0, "R1");
        check_reg(15, "R1");

        // R4: ramp operand fills distinct values
        issue(4'b1000, 4'd0, 4'd0, 4'd1, 32, 32'h1000_0000);
        busy_len(32, "R5");
        check_reg(1, "R4");
        issue(4'b1100, 4'd1, 4'd0, 4'd2, 32, 32'hdead_beef);
        busy_len(32, "R5");
        check_reg(2, "R4");

        // R3: each function on vector operands
        for (int f = 0; f < 8; f++) begin
            issue(4'(f), 4'd2, 4'd1, 4'(4 + f), 32, 32'd0);
            busy_len(32, "R5");
            check_reg(4 + f, "R3");
        end

        // R7: zero length leaves everything alone
        issue(4'b0000, 4'd1, 4'd2, 4'd2, 0, 32'd0);
        check("R7", 32'(busy), 32'd0, "busy after zero length");
        check_reg(2, "R7");

        // R8: partial-group tail
        issue(4'b1000, 4'd0, 4'd0, 4'd3, 13, 32'h55);
        busy_len(13, "R5");
        check_reg(3, "R8");
        issue(4'b0100, 4'd1, 4'd2, 4'd2, 25, 32'd0);
        busy_len(25, "R5");
        check_reg(2, "R8");

        // R9: destination doubles as both sources
        issue(4'b0000, 4'd2, 4'd2, 4'd2, 32, 32'd0);
        busy_len(32, "R5");
        check_reg(2, "R9");
        issue(4'b1001, 4'd1, 4'd0, 4'd1, 20, 32'h7);
        busy_len(20, "R5");
        check_reg(1, "R9");

        // R6: back-to-back issue, second reads first's result
        issue(4'b0100, 4'd1, 4'd2, 4'd13, 32, 32'd0);
        begin
            int wait_cyc = 0;
            issue_valid = 1'b1; issue_op = 4'b0000; issue_vs1 = 4'd13;
            issue_vs2 = 4'd1; issue_vd = 4'd14; issue_vl = 6'd32;
            while (!issue_ready) begin
                wait_cyc++;
                @(negedge clk);
            end
            check("R6", 32'(wait_cyc), 32'd3, "cycles refused before last group");
            check("R6", 32'(busy), 32'd1, "busy during last group");
            @(negedge clk);
            issue_valid = 1'b0;
            m_exec(4'b0000, 4'd13, 4'd1, 4'd14, 32, 32'd0);
            check("R6", 32'(busy), 32'd1, "second instruction started");
        end
        busy_len(32, "R5");
        check_reg(13, "R6");
        check_reg(14, "R6");

        // R10: valid while not ready has no effect
        issue(4'b0011, 4'd1, 4'd2, 4'd15, 32, 32'd0);
        issue_valid = 1'b1; issue_op = 4'b1000; issue_vs1 = 4'd0;
        issue_vd = 4'd12; issue_vl = 6'd32; issue_scalar = 32'hffff;
        @(negedge clk);
        @(negedge clk);
        issue_valid = 1'b0;
        busy_len(16, "R5");
        check_reg(12, "R10");
        check_reg(15, "R10");

        // lengths above the maximum clamp to 32
        issue(4'b1000, 4'd3, 4'd0, 4'd11, 45, 32'h99);
        busy_len(32, "R7");
        check_reg(11, "R7");

        // random mix
        for (int k = 0; k < 300; k++) begin
            int sel = int'($urandom % 8);
            int vl = (sel == 0) ? 0 : (sel == 1) ? 32 : int'($urandom % 33);
            logic [3:0] op = 4'($urandom);
            logic [3:0] d  = 4'($urandom);
            issue(op, 4'($urandom), 4'($urandom), d, vl, $urandom);
            busy_len(vl, "R5");
            check_reg(int'(d), "R2/R3");
        end
        for (int r = 0; r < 16; r++) check_reg(r, "R2");

        finish_run();
    end

endmodule